// File: doc/BRIEF.md
# Prescaled Cycle Counter

This block holds the free-running cycle counter of a processor performance-monitoring unit. The count is 64 bits wide by default. Software reaches it through a system-register access port, and all bits can be read and written there. A control interface shapes how the count advances. A clear strobe zeroes it. A pair of mode bits picks between advancing on every clock and advancing once per 64 clocks. A count-allow qualifier, produced by an external privilege and security filter, suppresses counting whenever it is low.

The update of the count is a small per-cycle decision with four named outcomes: `UPD_LOAD` (software write), `UPD_CLEAR` (clear strobe), `UPD_STEP` (advance by one) and `UPD_HOLD` (keep the value). They are tried in that order of priority. The advance condition depends on a rate mode, `MODE_FULL` or `MODE_DIV`, which is decoded from the two mode bits. A 6-bit prescaler counts allowed clocks. In `MODE_DIV` a step is taken only on the allowed clock where the prescaler reads all ones. A step from all ones wraps the count to zero and raises a one-cycle overflow pulse.

Top module: `pmu_cycle_counter`

## Requirements
- R1: `acc_hit` is high exactly when `acc_en` is high and the access fields equal op0=3, op1=3, CRn=9, CRm=13, op2=0.
- R2: During a read hit (`acc_hit` high, `acc_wr` low), `acc_rdata` combinationally shows the count as it stood before this cycle's update. At every other time it is zero.
- R3: A write hit loads `acc_wdata` exactly into the count at the next edge. It takes priority over clear and over stepping in the same cycle.
- R4: `ctl_clear` high zeroes the count at the next edge, unless a write hit occurs in the same cycle. It always zeroes the prescaler, and it takes priority over stepping.
- R5: `MODE_FULL` is in force when `ctl_long`=1 or `ctl_div`=0. In this mode the count advances by one on every clock where `cnt_allow` is high.
- R6: `MODE_DIV` is in force when `ctl_div`=1 and `ctl_long`=0. The prescaler adds one on every allowed clock in either mode. In `MODE_DIV` the count advances only on an allowed clock where the prescaler equals 2^PRE_W-1, which is 63 by default.
- R7: While `cnt_allow` is low, with no write hit and no clear, the count and the prescaler both hold.
- R8: A step from all ones wraps the count to zero. `ovf_pulse` is high for exactly the one cycle after that edge, and low at all other times.
- R9: After reset, `ovf_pulse` is low and the prescaler is zero. The count value is not defined until the first write or clear.
- R10: A write whose encoding does not match leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | System-register access valid |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Access encoding field op0 |
| acc_op1 | input | 3 | Access encoding field op1 |
| acc_crn | input | 4 | Access encoding field CRn |
| acc_crm | input | 4 | Access encoding field CRm |
| acc_op2 | input | 3 | Access encoding field op2 |
| acc_wdata | input | CNT_W (64) | Write data |
| acc_rdata | output | CNT_W (64) | Read data, zero unless read hit |
| acc_hit | output | 1 | Access selects this register |
| ctl_clear | input | 1 | Zero count and prescaler |
| ctl_long | input | 1 | Long-count select, forces `MODE_FULL` |
| ctl_div | input | 1 | Divide select |
| cnt_allow | input | 1 | Filter qualifier, counting allowed |
| ovf_pulse | output | 1 | One-cycle wrap indication |

## Verification
The bench builds the block with CNT_W=16 and PRE_W=3. With these values a wrap from all ones takes only a few cycles in `MODE_FULL`, and a divided step occurs every 8 allowed clocks. That makes the prescaler's phase across mode changes and allow gaps observable in short runs. It sweeps all four mode-bit combinations with both allow levels. It also sweeps every write/clear/allow combination for priority, and each of the five encoding fields off by one. A bench-side arithmetic model predicts the count and the overflow pulse on every cycle.

// File: rtl/pmu_cc_pkg.sv
package pmu_cc_pkg;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_STEP,
        UPD_CLEAR,
        UPD_LOAD
    } upd_e;

    typedef enum logic {
        MODE_FULL,
        MODE_DIV
    } mode_e;

    localparam logic [1:0] SEL_OP0 = 2'd3;
    localparam logic [2:0] SEL_OP1 = 3'd3;
    localparam logic [3:0] SEL_CRN = 4'd9;
    localparam logic [3:0] SEL_CRM = 4'd13;
    localparam logic [2:0] SEL_OP2 = 3'd0;

    function automatic mode_e pick_mode(input logic lng, input logic dv);
        mode_e m;
        unique case ({lng, dv})
            2'b01:   m = MODE_DIV;
            default: m = MODE_FULL;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pmu_cc_decode.sv
module pmu_cc_decode
    import pmu_cc_pkg::*;
(
    input  logic       en,
    input  logic       wr,
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit,
    output logic       rd_hit,
    output logic       wr_hit
);
    logic match;

    always_comb begin
        match  = (op0 == SEL_OP0) && (op1 == SEL_OP1) && (crn == SEL_CRN)
              && (crm == SEL_CRM) && (op2 == SEL_OP2);
        hit    = en && match;
        rd_hit = hit && !wr;
        wr_hit = hit && wr;
    end
endmodule

// File: rtl/pmu_cc_prescale.sv
module pmu_cc_prescale
    import pmu_cc_pkg::*;
#(
    parameter int PRE_W = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  allow,
    input  mode_e mode,
    output logic  tick
);
    logic wrap;

    generate
        if (PRE_W > 0) begin : g_pre
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     pre_q <= '0;
                else if (clear) pre_q <= '0;
                else if (allow) pre_q <= pre_q + 1'b1;
            end

            assign wrap = allow && (pre_q == {PRE_W{1'b1}});
        end else begin : g_nopre
            assign wrap = allow;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_DIV:  tick = wrap;
            MODE_FULL: tick = allow;
            default:   tick = allow;
        endcase
    end
endmodule

// File: rtl/pmu_cc_core.sv
module pmu_cc_core
    import pmu_cc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    upd_e             upd;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    always_comb begin
        if (load)       upd = UPD_LOAD;
        else if (clear) upd = UPD_CLEAR;
        else if (tick)  upd = UPD_STEP;
        else            upd = UPD_HOLD;
    end

    // count state carries no reset: its value is undefined until written or cleared
    always_ff @(posedge clk) begin
        unique case (upd)
            UPD_LOAD:  cnt_q <= wdata;
            UPD_CLEAR: cnt_q <= '0;
            UPD_STEP:  cnt_q <= cnt_q + 1'b1;
            UPD_HOLD:  cnt_q <= cnt_q;
            default:   cnt_q <= cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= (upd == UPD_STEP) && (cnt_q == ALL_ONES);
    end

    assign cnt = cnt_q;
    assign ovf = ovf_q;
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter
    import pmu_cc_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [1:0]       acc_op0,
    input  logic [2:0]       acc_op1,
    input  logic [3:0]       acc_crn,
    input  logic [3:0]       acc_crm,
    input  logic [2:0]       acc_op2,
    input  logic [CNT_W-1:0] acc_wdata,
    output logic [CNT_W-1:0] acc_rdata,
    output logic             acc_hit,
    input  logic             ctl_clear,
    input  logic             ctl_long,
    input  logic             ctl_div,
    input  logic             cnt_allow,
    output logic             ovf_pulse
);
    logic             rd_hit;
    logic             wr_hit;
    logic             tick;
    mode_e            mode;
    logic [CNT_W-1:0] count_q;

    assign mode = pick_mode(ctl_long, ctl_div);

    pmu_cc_decode u_dec (
        .en     (acc_en),
        .wr     (acc_wr),
        .op0    (acc_op0),
        .op1    (acc_op1),
        .crn    (acc_crn),
        .crm    (acc_crm),
        .op2    (acc_op2),
        .hit    (acc_hit),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit)
    );

    pmu_cc_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctl_clear),
        .allow (cnt_allow),
        .mode  (mode),
        .tick  (tick)
    );

    pmu_cc_core #(.CNT_W(CNT_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_hit),
        .clear (ctl_clear),
        .tick  (tick),
        .wdata (acc_wdata),
        .cnt   (count_q),
        .ovf   (ovf_pulse)
    );

    assign acc_rdata = rd_hit ? count_q : '0;
endmodule

// File: rtl/pmu_cc_checker.sv
module pmu_cc_checker #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_hit,
    input logic             acc_wr,
    input logic [CNT_W-1:0] acc_wdata,
    input logic [CNT_W-1:0] acc_rdata,
    input logic             ctl_clear,
    input logic             ctl_long,
    input logic             ctl_div,
    input logic             cnt_allow,
    input logic             ovf_pulse,
    input logic [CNT_W-1:0] cnt
);
    logic wr_now;
    assign wr_now = acc_hit && acc_wr;

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |=> cnt == $past(acc_wdata)); // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_clear && !wr_now) |=> cnt == '0); // R4

    AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_allow && (ctl_long || !ctl_div) && !ctl_clear && !wr_now)
        |=> cnt == $past(cnt) + 1'b1); // R5

    AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_allow && !ctl_clear && !wr_now) |=> $stable(cnt)); // R7

    AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> cnt == '0); // R8

    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse); // R8

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_hit && !acc_wr) |-> acc_rdata == '0); // R2
endmodule

bind pmu_cycle_counter pmu_cc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_hit   (acc_hit),
    .acc_wr    (acc_wr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .ctl_clear (ctl_clear),
    .ctl_long  (ctl_long),
    .ctl_div   (ctl_div),
    .cnt_allow (cnt_allow),
    .ovf_pulse (ovf_pulse),
    .cnt       (count_q)
);

// File: tb/test_pmu_cycle_counter.sv
module test_pmu_cycle_counter;
    localparam int W    = 16;
    localparam int PW   = 3;
    localparam int PMAX = (1 << PW) - 1;
    localparam logic [W-1:0] MAXC = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_en = 1'b0, acc_wr = 1'b0;
    logic [1:0]   acc_op0 = '0;
    logic [2:0]   acc_op1 = '0;
    logic [3:0]   acc_crn = '0, acc_crm = '0;
    logic [2:0]   acc_op2 = '0;
    logic [W-1:0] acc_wdata = '0;
    logic [W-1:0] acc_rdata;
    logic         acc_hit;
    logic         ctl_clear = 1'b0, ctl_long = 1'b0, ctl_div = 1'b0, cnt_allow = 1'b0;
    logic         ovf_pulse;

    int n_vec = 0;
    int n_bad = 0;

    logic [W-1:0] m_cnt = '0;
    int           m_pre = 0;
    bit           known = 1'b0;

    always #2 clk = ~clk;

    pmu_cycle_counter #(.CNT_W(W), .PRE_W(PW)) i_pmu_cycle_counter (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn),
        .acc_crm(acc_crm), .acc_op2(acc_op2), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_hit(acc_hit), .ctl_clear(ctl_clear),
        .ctl_long(ctl_long), .ctl_div(ctl_div), .cnt_allow(cnt_allow),
        .ovf_pulse(ovf_pulse)
    );

    task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string req);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0h expected %0h", req, $time, got, exp);
        end
    endtask

    // one clock: drive at negedge, check combinational outputs, model the edge, check ovf
    task automatic cyc(input logic wr, input logic rd, input logic clr,
                       input logic lng, input logic dv, input logic al,
                       input logic [W-1:0] wd, input int bad, input string req);
        bit divm, tick, exp_ovf, chk_ovf;
        acc_en    = wr | rd;
        acc_wr    = wr;
        acc_op0   = (bad == 1) ? 2'd2 : 2'd3;
        acc_op1   = (bad == 2) ? 3'd2 : 3'd3;
        acc_crn   = (bad == 3) ? 4'd8 : 4'd9;
        acc_crm   = (bad == 4) ? 4'd12 : 4'd13;
        acc_op2   = (bad == 5) ? 3'd1 : 3'd0;
        acc_wdata = wd;
        ctl_clear = clr;
        ctl_long  = lng;
        ctl_div   = dv;
        cnt_allow = al;
        #1;
        chk({63'd0, acc_hit}, {63'd0, (wr | rd) && bad == 0}, "R1");
        if (rd && !wr && bad == 0 && known)
            chk({{(64-W){1'b0}}, acc_rdata}, {{(64-W){1'b0}}, m_cnt}, {"R2 ", req});
        if (!(rd && !wr && bad == 0))
            chk({{(64-W){1'b0}}, acc_rdata}, 64'd0, "R2 idle");
        divm    = dv && !lng;
        tick    = al && (!divm || m_pre == PMAX);
        exp_ovf = 1'b0;
        chk_ovf = known;
        if (wr && bad == 0) begin
            m_cnt = wd; known = 1'b1;
        end else if (clr) begin
            m_cnt = '0; known = 1'b1;
        end else if (tick) begin
            exp_ovf = (m_cnt == MAXC);
            m_cnt   = m_cnt + 1'b1;
        end
        if (clr)     m_pre = 0;
        else if (al) m_pre = (m_pre + 1) % (PMAX + 1);
        @(posedge clk);
        @(negedge clk);
        if (chk_ovf) chk({63'd0, ovf_pulse}, {63'd0, exp_ovf}, {"R8 ", req});
    endtask

    task automatic rd_only(input string req);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk({63'd0, ovf_pulse}, 64'd0, "R9 ovf in reset");
        chk({63'd0, acc_hit}, 64'd0, "R1 no access in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk({63'd0, ovf_pulse}, 64'd0, "R9 ovf after reset");

        // R3: exact load; R9: prescaler zero after reset observed in divide mode
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 0, "R3 load");
        rd_only("R3 readback");
        for (int i = 0; i < 2 * (PMAX + 1); i++)
            cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '0, 0, "R6 R9 divide from reset");

        // R10 / R1: each encoding field off by one, write must be ignored
        for (int b = 1; b <= 5; b++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hBEEF, b, "R10 bad write");
            rd_only("R10 unchanged");
        end

        // R5 R6 R7: all mode combinations with both allow levels
        for (int mc = 0; mc < 4; mc++)
            for (int a = 0; a < 2; a++)
                for (int k = 0; k < 20; k++)
                    cyc(1'b0, 1'b1, 1'b0, mc[1], mc[0], a[0], '0, 0,
                        (mc == 1) ? "R6 divided" : (a == 0 ? "R7 blocked" : "R5 full"));

        // R6 R7: allow gaps in divide mode keep the prescaler phase
        for (int k = 0; k < 40; k++)
            cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, (k % 3) != 0, '0, 0, "R6 R7 gapped");

        // R3 R4: priority of write over clear over step, all combinations
        for (int v = 0; v < 8; v++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0F0F, 0, "R3 preset");
            cyc(v[2], 1'b0, v[1], 1'b0, 1'b0, v[0], 16'hA5C3, 0, "R4 priority");
            rd_only("R3 R4 priority result");
        end

        // R4: clear resets the prescaler mid-phase
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, '0, 0, "R6 advance");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, '0, 0, "R6 advance");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '0, 0, "R4 clear");
        for (int k = 0; k < 2 * (PMAX + 1); k++)
            cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '0, 0, "R4 prescaler cleared");

        // R8: wrap in full mode and in divided mode
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, MAXC - 16'd2, 0, "R8 preset");
        for (int k = 0; k < 6; k++)
            cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, 0, "R8 full wrap");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, MAXC, 0, "R8 preset");
        for (int k = 0; k < 2 * (PMAX + 1) + 2; k++)
            cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '0, 0, "R8 divided wrap");
        // R8: clear and write at all ones do not pulse
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, MAXC, 0, "R8 preset");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '0, 0, "R8 clear no pulse");
        rd_only("R4 cleared");

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule